// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Front End

This block is the software-facing half of a 16-channel DMA controller. A simple 32-bit memory-mapped bus reaches it. It stores each channel's transfer description: a word address, X and Y lengths, a small control field and a line stride. It also holds the shared interrupt, enable, loop and stop registers. Each transfer engine sits beside it. An engine receives a one-cycle start or stop command and a loop qualifier from this block, and it reports its done or half-buffer events back through `ch_event`.

Software programs the stride, control and length registers first and writes the address register last. That final address write starts the channel. Events set sticky status bits. A single interrupt line is high while any status bit is set together with its enable bit. The enable and loop registers have two write paths. Software can write the whole register at once, or it can write ones to a clear alias that clears only the chosen bits. A channel is allowed to loop only while both of its loop bits are set.

Top module: `dmac_regfile`

## Requirements
- R1: After reset every register reads 0, and `irq`, `ch_start`, `ch_stop` and `ch_loop` are all 0.
- R2: Channel n has a 16-byte window at byte offset n*0x10. The address is at +0x0, X length at +0x4, Y length at +0x8 and control at +0xC. Address and lengths read back all 32 bits. Control keeps only bits [5:0]: [3:0] is the channel id, bit 4 selects bursts of 4 words, and bit 5 selects memory-to-device when set. The upper control bits read 0.
- R3: The stride register for channel n sits at 0x100 + 4*n, holds a 32-bit word count and reads back what was written.
- R4: A write to channel n's address register raises `ch_start[n]` for exactly one cycle, in the cycle after the write edge.
- R5: Writing a 1 to bit n at 0x140 raises `ch_stop[n]` for one cycle after the write edge. Reading 0x140 returns 0.
- R6: A pulse on `ch_event[n]` sets status bit n at 0x144 from the next edge, and the bit stays set. Writing 1 to the bit clears it, and writing 0 leaves it unchanged. If an event and a clear land in the same cycle, the event wins.
- R7: The enable register at 0x148 takes a full write of bits [15:0]. Writing 1s to 0x14C clears only those enable bits. Reading 0x14C returns the enable register.
- R8: The loop register at 0x150 takes a full write of bits [15:0] and [31:16]. Writing 1s to 0x15C clears only those loop bits, and reading 0x15C returns the loop register. `ch_loop[n]` is high only while both bit n and bit n+16 are set.
- R9: `irq` is high exactly while some channel has both its status bit and its enable bit set.
- R10: Offsets 0x160 to 0x1FC read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 9 | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| ch_event | input | 16 | Per-channel done or half-buffer event |
| ch_start | output | 16 | One-cycle start command per channel |
| ch_stop | output | 16 | One-cycle stop command per channel |
| ch_loop | output | 16 | Loop permission per channel |
| irq | output | 1 | Combined interrupt |

## Verification
The bench aims at the clear paths. If the status register behaved as a plain register, a write of zeros would lose pending events. If it were cleared by the wrong rule, a clear arriving in the same cycle as a new event would swallow that event. If the clear aliases acted as plain stores, they would wipe the enable or loop bits that were written as 0. The bench sets only one half of a channel's loop pair and checks that `ch_loop` stays low, which catches a decoder that ORs the two bits instead of ANDing them. It also checks the start pulse on the highest channel and on a middle channel, the masking of the upper control bits, and the unmapped space. Together these expose an off-by-one in the window decode and any pulse that lasts longer than one cycle.

// File: rtl/dmac_regfile.sv
module dmac_regfile #(
  parameter int NCH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [8:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NCH-1:0]  ch_event,
  output logic [NCH-1:0]  ch_start,
  output logic [NCH-1:0]  ch_stop,
  output logic [NCH-1:0]  ch_loop,
  output logic            irq
);
  localparam logic [31:0] LOMASK = (32'd1 << NCH) - 32'd1;
  localparam logic [31:0] LMASK  = LOMASK | (LOMASK << 16);
  localparam logic [6:0]  W_STOP = 7'h50, W_STAT = 7'h51, W_EN = 7'h52,
                          W_ENCLR = 7'h53, W_LOOP = 7'h54, W_LOOPCLR = 7'h57;

  logic [31:0]    addr_r  [NCH];
  logic [31:0]    xlen_r  [NCH];
  logic [31:0]    ylen_r  [NCH];
  logic [5:0]     ctrl_r  [NCH];
  logic [31:0]    width_r [NCH];
  logic [NCH-1:0] stat_r, en_r;
  logic [31:0]    loop_r;

  logic [3:0] wch, sch;
  logic [1:0] off;
  logic [6:0] gw;
  logic       win_hit, stride_hit;
  logic [NCH-1:0] stat_clr;

  assign wch        = bus_addr[7:4];
  assign off        = bus_addr[3:2];
  assign sch        = bus_addr[5:2];
  assign gw         = bus_addr[8:2];
  assign win_hit    = !bus_addr[8] && (32'(wch) < NCH);
  assign stride_hit = (bus_addr[8:6] == 3'b100) && (32'(sch) < NCH);
  assign stat_clr   = (bus_wr && gw == W_STAT) ? bus_wdata[NCH-1:0] : '0;

  assign ch_loop = loop_r[NCH-1:0] & loop_r[16 +: NCH];
  assign irq     = |(stat_r & en_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        addr_r[i]  <= '0;
        xlen_r[i]  <= '0;
        ylen_r[i]  <= '0;
        ctrl_r[i]  <= '0;
        width_r[i] <= '0;
      end
      stat_r   <= '0;
      en_r     <= '0;
      loop_r   <= '0;
      ch_start <= '0;
      ch_stop  <= '0;
    end else begin
      ch_start <= '0;
      ch_stop  <= '0;
      stat_r   <= (stat_r & ~stat_clr) | ch_event;
      if (bus_wr) begin
        if (win_hit) begin
          case (off)
            2'd0: begin
              addr_r[wch]   <= bus_wdata;
              ch_start[wch] <= 1'b1;
            end
            2'd1: xlen_r[wch] <= bus_wdata;
            2'd2: ylen_r[wch] <= bus_wdata;
            default: ctrl_r[wch] <= bus_wdata[5:0];
          endcase
        end else if (stride_hit) begin
          width_r[sch] <= bus_wdata;
        end else begin
          case (gw)
            W_STOP:    ch_stop <= bus_wdata[NCH-1:0];
            W_EN:      en_r    <= bus_wdata[NCH-1:0];
            W_ENCLR:   en_r    <= en_r & ~bus_wdata[NCH-1:0];
            W_LOOP:    loop_r  <= bus_wdata & LMASK;
            W_LOOPCLR: loop_r  <= loop_r & ~bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (win_hit) begin
      case (off)
        2'd0: bus_rdata = addr_r[wch];
        2'd1: bus_rdata = xlen_r[wch];
        2'd2: bus_rdata = ylen_r[wch];
        default: bus_rdata = {26'd0, ctrl_r[wch]};
      endcase
    end else if (stride_hit) begin
      bus_rdata = width_r[sch];
    end else begin
      case (gw)
        W_STAT:            bus_rdata = 32'(stat_r);
        W_EN, W_ENCLR:     bus_rdata = 32'(en_r);
        W_LOOP, W_LOOPCLR: bus_rdata = loop_r;
        default:           bus_rdata = '0;
      endcase
    end
  end
endmodule

module dmac_regfile_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [8:0]     bus_addr,
  input logic [NCH-1:0] ch_event,
  input logic [NCH-1:0] ch_start,
  input logic [NCH-1:0] ch_stop,
  input logic           irq,
  input logic [NCH-1:0] stat_q,
  input logic [NCH-1:0] en_q
);
  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr[8] && bus_addr[3:2] == 2'd0 && 32'(bus_addr[7:4]) < NCH)
      |=> ($countones(ch_start) == 1));
  // R4
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_start));
  // R5
  stop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_stop != '0) |-> $past(bus_wr && bus_addr[8:2] == 7'h50));
  // R6
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(ch_event & en_q)) && !bus_wr) |=> irq);
endmodule

bind dmac_regfile dmac_regfile_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .ch_event(ch_event), .ch_start(ch_start), .ch_stop(ch_stop), .irq(irq),
  .stat_q(stat_r), .en_q(en_r)
);

// File: tb/dmac_regfile_bench.sv
module dmac_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] ch_event = '0;
  logic [15:0] ch_start, ch_stop, ch_loop;
  logic        irq;
  int errors = 0;
  int checks = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  dmac_regfile u_dmac_regfile (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_event(ch_event),
    .ch_start(ch_start), .ch_stop(ch_stop), .ch_loop(ch_loop), .irq(irq)
  );

  localparam int NV = 11;
  localparam logic [8:0]  V_ADDR [NV] = '{9'h000, 9'h034, 9'h0F8, 9'h05C, 9'h100,
                                          9'h13C, 9'h148, 9'h150, 9'h160, 9'h1FC, 9'h0A4};
  localparam logic [31:0] V_WR   [NV] = '{32'h12345678, 32'h00000034, 32'h000000FC, 32'hFFFFFFFF,
                                          32'h00000040, 32'h00000123, 32'hFFFFA5A5, 32'h00030003,
                                          32'h0000DEAD, 32'hFFFFFFFF, 32'hCAFEF00D};
  localparam logic [31:0] V_EXP  [NV] = '{32'h12345678, 32'h00000034, 32'h000000FC, 32'h0000003F,
                                          32'h00000040, 32'h00000123, 32'h0000A5A5, 32'h00030003,
                                          32'h00000000, 32'h00000000, 32'hCAFEF00D};
  localparam string V_REQ [NV] = '{"R2", "R2", "R2", "R2", "R3", "R3", "R7", "R8", "R10", "R10", "R2"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_event(input logic [15:0] e);
    @(negedge clk);
    ch_event = e;
    @(negedge clk);
    ch_event = '0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {15'd0, irq, ch_start}, 32'd0);
    check("R1", {ch_stop, ch_loop}, 32'd0);
    rd(9'h144, rv); check("R1", rv, 32'd0);
    rd(9'h148, rv); check("R1", rv, 32'd0);
    rd(9'h150, rv); check("R1", rv, 32'd0);

    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_WR[i]);
      rd(V_ADDR[i], rv);
      check(V_REQ[i], rv, V_EXP[i]);
    end
    // R10 unmapped writes left channel 0 address intact
    rd(9'h000, rv); check("R10", rv, 32'h12345678);

    // R4 start pulse
    wr(9'h070, 32'h00000AA0);
    check("R4", 32'(ch_start), 32'h0080);
    @(negedge clk);
    check("R4", 32'(ch_start), 32'h0000);
    wr(9'h0F0, 32'h1);
    check("R4", 32'(ch_start), 32'h8000);
    wr(9'h0F4, 32'h1);
    check("R4", 32'(ch_start), 32'h0000);

    // R5 stop
    wr(9'h140, 32'h00000011);
    check("R5", 32'(ch_stop), 32'h0011);
    rd(9'h140, rv); check("R5", rv, 32'd0);
    @(negedge clk);
    check("R5", 32'(ch_stop), 32'h0000);

    // R6 / R9 status and interrupt
    wr(9'h148, 32'h0);
    pulse_event(16'h0004);
    rd(9'h144, rv); check("R6", rv, 32'h4);
    check("R9", 32'(irq), 32'd0);
    wr(9'h148, 32'h4);
    check("R9", 32'(irq), 32'd1);
    wr(9'h144, 32'h0);
    rd(9'h144, rv); check("R6", rv, 32'h4);
    wr(9'h144, 32'h8);
    rd(9'h144, rv); check("R6", rv, 32'h4);
    wr(9'h144, 32'h4);
    rd(9'h144, rv); check("R6", rv, 32'h0);
    check("R9", 32'(irq), 32'd0);
    pulse_event(16'h0200);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 9'h144; bus_wdata = 32'h200; ch_event = 16'h0200;
    @(negedge clk);
    bus_wr = 1'b0; ch_event = '0;
    rd(9'h144, rv); check("R6", rv, 32'h200);

    // R7 enable clear alias
    wr(9'h148, 32'hFFFF);
    wr(9'h14C, 32'h00F0);
    rd(9'h148, rv); check("R7", rv, 32'hFF0F);
    rd(9'h14C, rv); check("R7", rv, 32'hFF0F);
    check("R9", 32'(irq), 32'd1);

    // R8 loop pair and clear alias
    wr(9'h150, 32'h00010001);
    check("R8", 32'(ch_loop), 32'h0001);
    wr(9'h150, 32'h00020006);
    check("R8", 32'(ch_loop), 32'h0002);
    wr(9'h15C, 32'h00020000);
    check("R8", 32'(ch_loop), 32'h0000);
    rd(9'h15C, rv); check("R8", rv, 32'h00000006);
    wr(9'h150, 32'h00020002);
    check("R8", 32'(ch_loop), 32'h0002);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule